// File: doc/BRIEF.md
# ADC Result Holding Stage with Overrun Policy

This block sits between an analog-to-digital converter and the consumers of its down-sampled data path. Each conversion result arrives as a 16-bit word with a one-cycle valid strobe and a tag that tells what kind of input was converted. Depending on that tag and two separate enables, the word is stored either as it is or with every bit flipped (ones' complement). The stored word is shown with a ready flag and, when enabled, a request for a DMA engine.

A consumer takes the word and pulses a read acknowledge. If a new word arrives while the held one is still unread, that is an overrun. A policy input picks the outcome: keep the unread word and drop the new one, or replace the unread word with the new one. Either way, a sticky overrun flag is raised and stays up until an explicit clear. A word that arrives in the same cycle as the acknowledge of the held word replaces it without an overrun.

Top module: `adc_result_path`

## Requirements
- R1: After a synchronous reset the outputs are: `rp_data` 0, `rp_ready` 0, `rp_dma_req` 0 and `rp_overrun` 0.
- R2: A `res_valid` pulse while no word is unread makes `rp_data` show the converted word and `rp_ready` read 1 on the next clock edge.
- R3: `res_kind` is coded 2'b00 single-ended positive, 2'b01 single-ended negative, 2'b10 differential and 2'b11 reserved. The stored word is the bitwise complement of `res_data` only when the kind is 2'b01 with `inv_sneg_en` set, or the kind is 2'b10 with `inv_diff_en` set. In every other case the word is stored unchanged.
- R4: With `ovr_keep_new` at 0, a valid word that arrives while a word is unread and no acknowledge is given is discarded. `rp_data` keeps the unread word.
- R5: With `ovr_keep_new` at 1, such a word replaces the unread word in `rp_data`.
- R6: Every overrun sets `rp_overrun` on the next edge, whatever the policy. The flag stays set until `ovr_clr` is pulsed. When an overrun and `ovr_clr` happen in the same cycle, the flag stays set.
- R7: `rd_ack` without `res_valid` clears `rp_ready` on the next edge and leaves `rp_data` unchanged.
- R8: `res_valid` together with `rd_ack` loads the new word, keeps `rp_ready` at 1 and does not set `rp_overrun`.
- R9: `rp_dma_req` is 1 exactly when `rp_ready` is 1 and `dma_en` is 1.
- R10: `rd_ack` while no word is unread changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe for a new conversion word |
| res_data | input | 16 | Raw conversion word |
| res_kind | input | 2 | Input type tag (coding in R3) |
| inv_sneg_en | input | 1 | Complement words from single-ended negative inputs |
| inv_diff_en | input | 1 | Complement words from differential inputs |
| ovr_keep_new | input | 1 | Overrun policy: 0 keeps the old word, 1 keeps the new word |
| dma_en | input | 1 | Allows the DMA request |
| rd_ack | input | 1 | Consumer has read the held word |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rp_data | output | 16 | Held result word |
| rp_ready | output | 1 | An unread word is held |
| rp_dma_req | output | 1 | DMA request for the held word |
| rp_overrun | output | 1 | Sticky overrun flag |

## Verification
The polarity logic is swept over all four kind codes, both enables and four data words: all zeros, all ones and two mixed words. This separates a complement from a pass-through, and a mix-up between the two enables, for every combination. The overrun tests repeat one arrival pattern, a second word with no acknowledge, under each policy. The data seen afterwards tells which word was kept, while the flag shows that overrun detection does not depend on the policy. Separate cycles combine arrival with acknowledge, acknowledge with no word, and overrun with a clear. These tell apart the priority cases around the ready and overrun state.

// File: rtl/adc_rp_pkg.sv
package adc_rp_pkg;

    parameter int RES_W  = 16;
    parameter int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_SE_POS = 2'b00,
        KIND_SE_NEG = 2'b01,
        KIND_DIFF   = 2'b10,
        KIND_RSVD   = 2'b11
    } kind_e;

    typedef struct packed {
        logic [RES_W-1:0] word;
        logic             ready;
        logic             overrun;
    } hold_state_t;

    function automatic logic need_flip(input logic [KIND_W-1:0] kind,
                                       input logic sneg_en,
                                       input logic diff_en);
        logic f;
        unique case (kind_e'(kind))
            KIND_SE_NEG: f = sneg_en;
            KIND_DIFF:   f = diff_en;
            default:     f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/adc_rp_polarity.sv
module adc_rp_polarity #(
    parameter int W  = adc_rp_pkg::RES_W,
    parameter int KW = adc_rp_pkg::KIND_W
) (
    input  logic [W-1:0]  in_word,
    input  logic [KW-1:0] in_kind,
    input  logic          sneg_en,
    input  logic          diff_en,
    output logic [W-1:0]  out_word
);
    logic flip;

    always_comb flip = adc_rp_pkg::need_flip(in_kind, sneg_en, diff_en);

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign out_word[b] = in_word[b] ^ flip;
    end
endmodule

// File: rtl/adc_rp_hold.sv
module adc_rp_hold #(
    parameter int W = adc_rp_pkg::RES_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_word,
    input  logic         keep_new,
    input  logic         ack,
    input  logic         clr_ovr,
    output logic [W-1:0] q_word,
    output logic         q_ready,
    output logic         q_ovr
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         ready;
        logic         overrun;
    } st_t;

    st_t st_q, st_d;
    logic ovr_ev, load;

    always_comb begin
        ovr_ev = in_valid && st_q.ready && !ack;
        load   = in_valid && (!st_q.ready || ack || keep_new);
        st_d   = st_q;
        if (load) st_d.word = in_word;
        if (in_valid)      st_d.ready = 1'b1;
        else if (ack)      st_d.ready = 1'b0;
        if (ovr_ev)        st_d.overrun = 1'b1;
        else if (clr_ovr)  st_d.overrun = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q_word  = st_q.word;
    assign q_ready = st_q.ready;
    assign q_ovr   = st_q.overrun;

    a_r2_valid_sets_ready: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> q_ready);
    a_r4_keep_old: assert property (@(posedge clk) disable iff (rst)
        (in_valid && q_ready && !ack && !keep_new) |=> $stable(q_word));
    a_r5_keep_new: assert property (@(posedge clk) disable iff (rst)
        (in_valid && q_ready && !ack && keep_new) |=> (q_word == $past(in_word)));
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (q_ovr && !clr_ovr) |=> q_ovr);
    a_r6_set: assert property (@(posedge clk) disable iff (rst)
        (in_valid && q_ready && !ack) |=> q_ovr);
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !in_valid) |=> (!q_ready && $stable(q_word)));
    a_r8_no_false_ovr: assert property (@(posedge clk) disable iff (rst)
        (!q_ovr && (ack || !in_valid || !q_ready)) |=> !q_ovr || $past(q_ovr));
endmodule

// File: rtl/adc_result_path.sv
module adc_result_path #(
    parameter int W  = adc_rp_pkg::RES_W,
    parameter int KW = adc_rp_pkg::KIND_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_valid,
    input  logic [W-1:0]  res_data,
    input  logic [KW-1:0] res_kind,
    input  logic          inv_sneg_en,
    input  logic          inv_diff_en,
    input  logic          ovr_keep_new,
    input  logic          dma_en,
    input  logic          rd_ack,
    input  logic          ovr_clr,
    output logic [W-1:0]  rp_data,
    output logic          rp_ready,
    output logic          rp_dma_req,
    output logic          rp_overrun
);
    logic [W-1:0] pol_word;

    adc_rp_polarity #(.W(W), .KW(KW)) u_pol (
        .in_word (res_data),
        .in_kind (res_kind),
        .sneg_en (inv_sneg_en),
        .diff_en (inv_diff_en),
        .out_word(pol_word)
    );

    adc_rp_hold #(.W(W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .in_valid(res_valid),
        .in_word (pol_word),
        .keep_new(ovr_keep_new),
        .ack     (rd_ack),
        .clr_ovr (ovr_clr),
        .q_word  (rp_data),
        .q_ready (rp_ready),
        .q_ovr   (rp_overrun)
    );

    assign rp_dma_req = rp_ready && dma_en;

    a_r9_dma_gated: assert property (@(posedge clk) disable iff (rst)
        rp_dma_req |-> (rp_ready && dma_en));
    a_r10_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !res_valid && !rp_ready && !ovr_clr) |=> ($stable(rp_data) && !rp_ready && $stable(rp_overrun)));
endmodule

// File: tb/sim_adc_result_path.sv
module sim_adc_result_path;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 0, inv_sneg_en = 0, inv_diff_en = 0;
    logic        ovr_keep_new = 0, dma_en = 0, rd_ack = 0, ovr_clr = 0;
    logic [15:0] res_data = '0;
    logic [1:0]  res_kind = '0;
    logic [15:0] rp_data;
    logic        rp_ready, rp_dma_req, rp_overrun;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_result_path u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic load(input logic [15:0] d, input logic ack);
        res_valid = 1; res_data = d; res_kind = 2'b00; rd_ack = ack;
        tick();
        res_valid = 0; rd_ack = 0;
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h1234;
        tick(); tick();
        rst = 0;
        chk("R1 data", rp_data, 16'h0);
        chk("R1 ready", {15'b0, rp_ready}, 16'h0);
        chk("R1 dma", {15'b0, rp_dma_req}, 16'h0);
        chk("R1 ovr", {15'b0, rp_overrun}, 16'h0);

        // R3 / R8 sweep: each load carries an ack, so no overrun ever
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 2; s++)
                    for (int d = 0; d < 2; d++) begin
                        logic flip;
                        flip = (k == 1 && s == 1) || (k == 2 && d == 1);
                        inv_sneg_en = s[0]; inv_diff_en = d[0];
                        res_valid = 1; res_data = pats[p]; res_kind = k[1:0]; rd_ack = 1;
                        tick();
                        res_valid = 0; rd_ack = 0;
                        chk("R3 polarity", rp_data, flip ? ~pats[p] : pats[p]);
                        chk("R8 ready kept", {15'b0, rp_ready}, 16'h1);
                    end
        inv_sneg_en = 0; inv_diff_en = 0;
        chk("R8 no overrun", {15'b0, rp_overrun}, 16'h0);
        chk("R2 ready", {15'b0, rp_ready}, 16'h1);

        // R9 dma gating
        dma_en = 0; #1;
        chk("R9 dma off", {15'b0, rp_dma_req}, 16'h0);
        dma_en = 1; #1;
        chk("R9 dma on", {15'b0, rp_dma_req}, 16'h1);

        // R7 ack clears ready, keeps data
        rd_ack = 1; tick(); rd_ack = 0;
        chk("R7 ready", {15'b0, rp_ready}, 16'h0);
        chk("R7 data", rp_data, 16'h1234);
        chk("R9 dma after ack", {15'b0, rp_dma_req}, 16'h0);

        // R10 idle ack
        rd_ack = 1; tick(); rd_ack = 0;
        chk("R10 ready", {15'b0, rp_ready}, 16'h0);
        chk("R10 data", rp_data, 16'h1234);
        chk("R10 ovr", {15'b0, rp_overrun}, 16'h0);

        // R2 fresh load
        load(16'h0A0A, 0);
        chk("R2 data", rp_data, 16'h0A0A);
        chk("R2 ready", {15'b0, rp_ready}, 16'h1);

        // R4 keep old
        ovr_keep_new = 0;
        load(16'hBEEF, 0);
        chk("R4 data kept", rp_data, 16'h0A0A);
        chk("R4 ready", {15'b0, rp_ready}, 16'h1);
        chk("R6 ovr set policy0", {15'b0, rp_overrun}, 16'h1);
        tick(); tick();
        chk("R6 sticky", {15'b0, rp_overrun}, 16'h1);
        ovr_clr = 1; tick(); ovr_clr = 0;
        chk("R6 cleared", {15'b0, rp_overrun}, 16'h0);

        // R5 keep new
        ovr_keep_new = 1;
        load(16'hC0DE, 0);
        chk("R5 data replaced", rp_data, 16'hC0DE);
        chk("R6 ovr set policy1", {15'b0, rp_overrun}, 16'h1);
        ovr_clr = 1; tick(); ovr_clr = 0;
        chk("R6 cleared again", {15'b0, rp_overrun}, 16'h0);

        // R6 overrun and clear in the same cycle: set wins
        ovr_clr = 1;
        load(16'h7777, 0);
        ovr_clr = 0;
        chk("R6 set beats clear", {15'b0, rp_overrun}, 16'h1);
        chk("R5 data replaced 2", rp_data, 16'h7777);

        // R1 reset again
        rst = 1; tick(); rst = 0;
        chk("R1 ready after reset", {15'b0, rp_ready}, 16'h0);
        chk("R1 ovr after reset", {15'b0, rp_overrun}, 16'h0);
        chk("R1 data after reset", rp_data, 16'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule